// File: doc/BRIEF.md
# Dual-Scan Panel Stream Capture

This block listens on the panel side of a passive-matrix, dual-scan LCD link and rebuilds a 640x400 monochrome image as bytes in an external memory. Each sample on the 8-bit bus carries four pixels for a row in the top half of the screen and four pixels for the row 200 lines further down. The block takes two such samples in turn, joins their top-half nibbles into one byte and their bottom-half nibbles into another, and issues two memory writes. Each byte holds 8 pixels, with the leftmost pixel in the MSB.

The byte clock, line pulse and frame pulse come from a foreign clock domain. All of them pass through two-flop synchronizers into the capture clock, which must run at least four times faster than the byte clock. The frame pulse comes at the end of the first line, not before it. The row counter therefore restarts at row 1 when a frame pulse arrives. The block makes no write until the first frame pulse after reset has set its position. It flags a line that has the wrong length and a frame that has the wrong line count.

Top module: `dscan_capture`

## Requirements
- R1: While reset is held, and in the cycle after it, `wr_en`, `wr_addr`, `wr_data`, `err_line` and `err_frame` are all zero.
- R2: No write is issued before the first frame pulse after reset. Samples and line pulses that arrive before it only move internal counters.
- R3: For an even column c (counting samples from 0 after a line or frame pulse) and the odd column c+1 that follows it, the block writes one byte. Its data is {bus[7:4] of sample c, bus[7:4] of sample c+1}, and its address is row*80 + c/2, where row is the current top-half row.
- R4: In the cycle after each top-half write, the block writes {bus[3:0] of sample c, bus[3:0] of sample c+1} to address (row+200)*80 + c/2.
- R5: After a frame pulse, the next captured line is top row 1. Each line pulse advances the row by one. Row 199 wraps to row 0.
- R6: A line pulse that arrives after lock with a sample count other than 160 sets `err_line`. The flag stays set until the next frame pulse. That frame pulse reloads the flag with the result of its own length check.
- R7: At a frame pulse that follows an earlier frame pulse, `err_frame` is reloaded with 1 when the number of line pulses since the previous frame pulse is not 199, and with 0 otherwise. The frame pulse's own line pulse is not counted.
- R8: Samples beyond the 160th in a line produce no write.
- R9: When the `INVERT` parameter is 1, every data bit written is the complement of the value written with `INVERT` = 0.
- R10: Every write address is below 32000. Writes come in pairs, and each pair starts with a top-half address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, at least 4x the byte clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_clk_in | input | 1 | Asynchronous byte clock; the bus is sampled on its rising edge |
| line_pulse_in | input | 1 | Asynchronous end-of-line pulse |
| frame_pulse_in | input | 1 | Asynchronous frame pulse, coincident with the end of row 0 |
| bus_in | input | 8 | Panel data: top-half nibble in bits 7..4, bottom-half nibble in bits 3..0 |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Linear byte address, row*80 + byte column |
| wr_data | output | 8 | Eight pixels, MSB leftmost, 1 = black |
| err_line | output | 1 | A line had the wrong sample count |
| err_frame | output | 1 | A frame had the wrong line count |

## Verification
The hardest state to reach is a mistimed frame that arrives after lock. This means a short or long line, or a frame with a missing line, all while the row counter keeps producing addresses that the model can still predict. The bench reaches this state in three steps. It first drives whole unlocked lines, then full well-formed frames, and only then single malformed lines and a frame with one line left out. A reduced geometry keeps each frame to a few hundred cycles. A second instance with inverted data shares the same stimulus, so R9 is checked on every write.

// File: rtl/dscan_pkg.sv
package dscan_pkg;
  localparam int unsigned DEF_SAMPLES   = 160;
  localparam int unsigned DEF_HALF_ROWS = 200;
  localparam int unsigned PIX_W         = 8;
  localparam int unsigned NIB_W         = PIX_W / 2;
  localparam int unsigned EV_W          = 3;
  localparam int unsigned EV_BYTE       = 0;
  localparam int unsigned EV_LINE       = 1;
  localparam int unsigned EV_FRAME      = 2;
endpackage

// File: rtl/dscan_sync.sv
module dscan_sync #(
  parameter int unsigned EVW = 3,
  parameter int unsigned DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [EVW-1:0] ev_in,
  input  logic [DW-1:0]  data_in,
  output logic [EVW-1:0] ev_rise,
  output logic [DW-1:0]  data_out
);
  logic [EVW-1:0] ev_s1, ev_s2, ev_s3;
  logic [DW-1:0]  d_s1, d_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_s1 <= '0;
      ev_s2 <= '0;
      ev_s3 <= '0;
      d_s1  <= '0;
      d_s2  <= '0;
    end else begin
      ev_s1 <= ev_in;
      ev_s2 <= ev_s1;
      ev_s3 <= ev_s2;
      d_s1  <= data_in;
      d_s2  <= d_s1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < EVW; gi++) begin : g_edge
      assign ev_rise[gi] = ev_s2[gi] & ~ev_s3[gi];
    end
  endgenerate

  assign data_out = d_s2;
endmodule

// File: rtl/dscan_tracker.sv
module dscan_tracker #(
  parameter int unsigned SAMPLES   = 160,
  parameter int unsigned HALF_ROWS = 200,
  localparam int unsigned COL_W = $clog2(SAMPLES + 2),
  localparam int unsigned ROW_W = $clog2(HALF_ROWS + 1),
  localparam int unsigned LN_W  = $clog2(HALF_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_ev,
  input  logic             line_ev,
  input  logic             frame_ev,
  output logic             locked,
  output logic             take,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             err_line,
  output logic             err_frame
);
  localparam logic [COL_W-1:0] S_C     = COL_W'(SAMPLES);
  localparam logic [COL_W-1:0] COL_MAX = '1;
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(HALF_ROWS - 1);
  localparam logic [ROW_W-1:0] ROW_AFTER_FRAME = (HALF_ROWS > 1) ? ROW_W'(1) : '0;
  localparam logic [LN_W-1:0]  LN_GOOD = LN_W'(HALF_ROWS - 1);
  localparam logic [LN_W-1:0]  LN_MAX  = '1;

  logic [LN_W-1:0] lines;

  assign take = sample_ev && locked && !line_ev && !frame_ev && (col < S_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      col       <= '0;
      row       <= '0;
      lines     <= '0;
      err_line  <= 1'b0;
      err_frame <= 1'b0;
    end else if (frame_ev) begin
      locked    <= 1'b1;
      col       <= '0;
      row       <= ROW_AFTER_FRAME;
      lines     <= '0;
      err_line  <= locked && (col != S_C);
      err_frame <= locked && (lines != LN_GOOD);
    end else if (line_ev) begin
      col <= '0;
      row <= (row == ROW_LAST) ? '0 : row + 1'b1;
      if (lines != LN_MAX) lines <= lines + 1'b1;
      if (locked && (col != S_C)) err_line <= 1'b1;
    end else if (sample_ev && (col != COL_MAX)) begin
      col <= col + 1'b1;
    end
  end
endmodule

// File: rtl/dscan_packer.sv
module dscan_packer #(
  parameter int unsigned SAMPLES   = 160,
  parameter int unsigned HALF_ROWS = 200,
  parameter bit          INVERT    = 1'b0,
  parameter int unsigned ADDR_W    = 15,
  localparam int unsigned COL_W = $clog2(SAMPLES + 2),
  localparam int unsigned ROW_W = $clog2(HALF_ROWS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  input  logic [7:0]        bus,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int unsigned BPR = SAMPLES / 2;
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(HALF_ROWS * BPR);

  logic [7:0]        pix;
  logic [3:0]        hold_hi, hold_lo;
  logic              pend;
  logic [ADDR_W-1:0] pend_addr, base;
  logic [7:0]        pend_data;

  assign pix  = bus ^ {8{INVERT}};
  assign base = ADDR_W'(int'(row) * BPR + int'(col >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      hold_hi   <= '0;
      hold_lo   <= '0;
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      wr_en <= 1'b0;
      pend  <= 1'b0;
      if (pend) begin
        wr_en   <= 1'b1;
        wr_addr <= pend_addr;
        wr_data <= pend_data;
      end
      if (take) begin
        if (!col[0]) begin
          hold_hi <= pix[7:4];
          hold_lo <= pix[3:0];
        end else begin
          wr_en     <= 1'b1;
          wr_addr   <= base;
          wr_data   <= {hold_hi, pix[7:4]};
          pend      <= 1'b1;
          pend_addr <= base + OFF;
          pend_data <= {hold_lo, pix[3:0]};
        end
      end
    end
  end
endmodule

// File: rtl/dscan_capture.sv
module dscan_capture
  import dscan_pkg::*;
#(
  parameter int unsigned SAMPLES   = DEF_SAMPLES,
  parameter int unsigned HALF_ROWS = DEF_HALF_ROWS,
  parameter bit          INVERT    = 1'b0,
  localparam int unsigned ADDR_W = $clog2(2 * HALF_ROWS * (SAMPLES / 2))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_clk_in,
  input  logic              line_pulse_in,
  input  logic              frame_pulse_in,
  input  logic [7:0]        bus_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              err_line,
  output logic              err_frame
);
  localparam int unsigned COL_W = $clog2(SAMPLES + 2);
  localparam int unsigned ROW_W = $clog2(HALF_ROWS + 1);

  logic [EV_W-1:0]  ev_rise;
  logic [PIX_W-1:0] bus_s;
  logic             sample_ev, line_ev, frame_ev, locked, take;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;

  dscan_sync #(.EVW(EV_W), .DW(PIX_W)) u_sync (
    .clk(clk), .rst(rst),
    .ev_in({frame_pulse_in, line_pulse_in, byte_clk_in}),
    .data_in(bus_in),
    .ev_rise(ev_rise),
    .data_out(bus_s)
  );

  assign sample_ev = ev_rise[EV_BYTE];
  assign line_ev   = ev_rise[EV_LINE];
  assign frame_ev  = ev_rise[EV_FRAME];

  dscan_tracker #(.SAMPLES(SAMPLES), .HALF_ROWS(HALF_ROWS)) u_track (
    .clk(clk), .rst(rst),
    .sample_ev(sample_ev), .line_ev(line_ev), .frame_ev(frame_ev),
    .locked(locked), .take(take), .col(col), .row(row),
    .err_line(err_line), .err_frame(err_frame)
  );

  dscan_packer #(.SAMPLES(SAMPLES), .HALF_ROWS(HALF_ROWS), .INVERT(INVERT),
                 .ADDR_W(ADDR_W)) u_pack (
    .clk(clk), .rst(rst),
    .take(take), .col(col), .row(row), .bus(bus_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/dscan_capture_chk.sv
module dscan_capture_chk #(
  parameter int unsigned SAMPLES   = 160,
  parameter int unsigned HALF_ROWS = 200,
  parameter int unsigned ADDR_W    = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              locked,
  input logic              line_ev,
  input logic              frame_ev,
  input logic              err_line,
  input logic              err_frame
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(HALF_ROWS * (SAMPLES / 2));
  localparam logic [ADDR_W:0]   TOP = (ADDR_W+1)'(2 * HALF_ROWS * (SAMPLES / 2));

  assert_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < OFF) |=> (wr_en && wr_addr == $past(wr_addr) + OFF));

  assert_range_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_addr} < TOP));

  assert_no_early_write_R2: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !wr_en);

  assert_lock_holds_R5: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  assert_ferr_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err_frame) |-> $past(frame_ev));

  assert_lerr_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_line) |-> $past(line_ev || frame_ev));
endmodule

bind dscan_capture dscan_capture_chk #(
  .SAMPLES(SAMPLES), .HALF_ROWS(HALF_ROWS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .locked(locked), .line_ev(line_ev), .frame_ev(frame_ev),
  .err_line(err_line), .err_frame(err_frame)
);

// File: tb/sim_dscan_capture.sv
module sim_dscan_capture;
  localparam int S   = 16;
  localparam int H   = 6;
  localparam int BPR = S / 2;
  localparam int OFF = H * BPR;
  localparam int AW  = $clog2(2 * H * BPR);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, lp = 1'b0, fp = 1'b0;
  logic [7:0] bus = '0;
  logic          we0, we1, el0, ef0, el1, ef1;
  logic [AW-1:0] a0, a1;
  logic [7:0]    d0, d1;

  always #4 clk = ~clk;

  dscan_capture #(.SAMPLES(S), .HALF_ROWS(H), .INVERT(1'b0)) u0 (
    .clk(clk), .rst(rst), .byte_clk_in(bclk), .line_pulse_in(lp),
    .frame_pulse_in(fp), .bus_in(bus), .wr_en(we0), .wr_addr(a0),
    .wr_data(d0), .err_line(el0), .err_frame(ef0));

  dscan_capture #(.SAMPLES(S), .HALF_ROWS(H), .INVERT(1'b1)) u1 (
    .clk(clk), .rst(rst), .byte_clk_in(bclk), .line_pulse_in(lp),
    .frame_pulse_in(fp), .bus_in(bus), .wr_en(we1), .wr_addr(a1),
    .wr_data(d1), .err_line(el1), .err_frame(ef1));

  int vectors = 0, fails = 0;
  int q0a[$], q0d[$], q1a[$], q1d[$];
  bit m_locked = 0, m_lerr = 0, m_ferr = 0;
  int m_col = 0, m_row = 0, m_lines = 0;
  logic [3:0] m_hh, m_hl;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison of both instances against the expected write queues.
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (we0) begin
        if (q0a.size() == 0) begin
          fails++;
          $display("FAIL R2 actual=write@%0d expected=no write", a0);
        end else begin
          int ea, ed;
          ea = q0a.pop_front();
          ed = q0d.pop_front();
          if (int'(a0) != ea || int'(d0) != ed) begin
            fails++;
            $display("FAIL %s actual=%0d/%02h expected=%0d/%02h",
                     (ea < OFF) ? "R3" : "R4", a0, d0, ea, ed);
          end
        end
      end
      if (we1) begin
        if (q1a.size() == 0) begin
          fails++;
          $display("FAIL R9 actual=write@%0d expected=no write", a1);
        end else begin
          int ea, ed;
          ea = q1a.pop_front();
          ed = q1d.pop_front();
          if (int'(a1) != ea || int'(d1) != ed) begin
            fails++;
            $display("FAIL R9 actual=%0d/%02h expected=%0d/%02h", a1, d1, ea, ed);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample();
    logic [7:0] v;
    v = 8'($urandom);
    if (m_locked && m_col < S) begin
      if (m_col % 2 == 0) begin
        m_hh = v[7:4];
        m_hl = v[3:0];
      end else begin
        int base;
        base = m_row * BPR + m_col / 2;
        q0a.push_back(base);       q0d.push_back({m_hh, v[7:4]});
        q0a.push_back(base + OFF); q0d.push_back({m_hl, v[3:0]});
        q1a.push_back(base);       q1d.push_back(8'(~{m_hh, v[7:4]}));
        q1a.push_back(base + OFF); q1d.push_back(8'(~{m_hl, v[3:0]}));
      end
    end
    m_col++;
    bclk = 1'b0; bus = v; tick(3);
    bclk = 1'b1; tick(3);
    bclk = 1'b0;
  endtask

  task automatic line(input int n, input bit fr);
    for (int i = 0; i < n; i++) sample();
    if (fr) begin
      m_lerr  = m_locked && (m_col != S);
      m_ferr  = m_locked && (m_lines != H - 1);
      m_locked = 1; m_col = 0; m_row = 1; m_lines = 0;
    end else begin
      if (m_locked && m_col != S) m_lerr = 1;
      m_col = 0;
      m_row = (m_row == H - 1) ? 0 : m_row + 1;
      m_lines++;
    end
    tick(2); lp = 1'b1; fp = fr; tick(2); lp = 1'b0; fp = 1'b0; tick(6);
    chk("R6 err_line", el0, m_lerr);
    chk("R7 err_frame", ef0, m_ferr);
  endtask

  // One frame: rows 1..H-1 then row 0 closed by the frame pulse (R5).
  task automatic frame(input int skip_lines);
    for (int r = 1; r < H - skip_lines; r++) line(S, 0);
    line(S, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    chk("R1 wr_en", we0, 0);
    chk("R1 wr_addr", a0, 0);
    chk("R1 wr_data", d0, 0);
    chk("R1 err_line", el0, 0);
    chk("R1 err_frame", ef0, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 wr_en after release", we0, 0);
    // R2: unlocked lines, including a short one, give no writes and no flags.
    line(S, 0);
    line(S - 3, 0);
    line(S, 0);
    line(S, 1);
    // R3 R4 R5: two well-formed frames.
    frame(0);
    frame(0);
    // R6: short line raises the flag; the next clean frame reloads it.
    line(S - 4, 0);
    for (int r = 2; r < H; r++) line(S, 0);
    line(S, 1);
    // R8: long line raises the flag and adds no writes.
    line(S + 3, 0);
    for (int r = 2; r < H; r++) line(S, 0);
    line(S, 1);
    // R7: frame missing a line, then a clean one.
    frame(1);
    frame(0);
    tick(20);
    chk("R3 queue drained", q0a.size(), 0);
    chk("R9 queue drained", q1a.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule